// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the privileged control state of a 32-bit core: the mode and interrupt-enable word, the interrupt cause word, the two return addresses, the vector base, the lookup-index and address-space registers, the user hardware-register enable bits and the load-link address. Software reaches it by a register number and a select code. The read port is combinational. The write port is qualified by `wr_en` and takes effect at the next rising clock edge. Each register filters incoming data through its own write mask, so bits that are fixed or read-only never change.

Beside the register port, the block takes a 2-bit operation code for return-from-exception, enable-interrupt and disable-interrupt. It drives a registered interrupt request that is recomputed on edges of the interrupt-enable bit. It also drives a combinational fault flag for hardware-register reads made in user mode, and a one-cycle pulse that tells the translation logic to flush when the address-space identifier changes. All pins are plain control and status pins. There is no valid/ready flow, so there is no back-pressure: the block accepts a write and an operation in every cycle.

Register map as {number, select}:
- index {0,0}
- hardware enable {7,0}
- address-space {10,0}
- status {12,0}
- cause {13,0}
- exception return address {14,0}
- read-only identity {15,0}
- vector base {15,1}
- link address {17,0}
- error return address {30,0}

Top module: `priv_ctrl_regs`

## Requirements
- R1: After reset every register reads zero, except the vector base, which reads 0x80000000. An unmapped {number, select} pair reads zero. The identity register {15,0} always reads `PRID_VAL`, and writes to it are ignored. The exception return address, error return address and link address store all 32 written bits.
- R2: A status write stores only the bits in 0xFA78FF01. Written bits 4, 2 and 1 are held as the user, error-level and exception-level flags, and they read back in those bit positions.
- R3: A cause write changes only the bits in 0x00C00300. Cause bits 15:10 read back the `irq_lines` input, registered for one cycle.
- R4: `irq_req` rises in the cycle after status bit 0 (IE) goes from 0 to 1, provided that exception level, error level and `dbg_mode` are all clear afterwards and that status[15:8] AND cause[15:8] is nonzero.
- R5: `irq_req` falls in the cycle after IE goes from 1 to 0. In every other case it holds its value, including after cause writes.
- R6: Operation code 3 (disable) clears IE and drops `irq_req`. During that cycle `di_old` shows the status value as it was before the operation.
- R7: Operation code 2 (enable) sets IE, and the interrupt request is raised under the rule of R4.
- R8: Operation code 1 (return) drives `eret_pc` with the error return address when error level is set, and with the exception return address otherwise. It clears error level in the first case and exception level in the second, and it sets the link address to 1.
- R9: When a register write and an operation fall in the same cycle, the write lands first and the operation then applies to the result. The choice made by a return follows the error-level flag held before that cycle.
- R10: A vector-base write forces bit 31 to 1 and keeps only bits 29:12 of the written value.
- R11: The hardware enable register keeps its low 4 bits. In user mode (user flag set, with exception level, error level and `dbg_mode` all clear), `hwr_fault` is high for a read of hardware register n unless n < 4 and enable bit n is set.
- R12: An address-space write is masked with 0xFFFFE0FF. `tlb_flush` pulses for one cycle, in the cycle after the write, only when bits 7:0 change.
- R13: An index write stores only its low log2(`TLB_ENTRIES`) bits. Bit 31 is never changed by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write enable |
| wr_num | input | 5 | Write register number |
| wr_sel | input | 3 | Write select |
| wr_data | input | 32 | Write data |
| rd_num | input | 5 | Read register number |
| rd_sel | input | 3 | Read select |
| rd_data | output | 32 | Read data (combinational) |
| op_code | input | 2 | 0 none, 1 return, 2 enable, 3 disable |
| eret_pc | output | 32 | Return target |
| di_old | output | 32 | Status value before this cycle |
| dbg_mode | input | 1 | Debug mode active |
| irq_lines | input | 6 | Hardware interrupt lines |
| irq_req | output | 1 | Registered interrupt request |
| hwr_req | input | 1 | User hardware-register read attempt |
| hwr_num | input | 5 | Hardware register number |
| hwr_fault | output | 1 | Reserved-instruction fault |
| tlb_flush | output | 1 | One-cycle flush pulse |

## Verification
The functions that can coincide are a status write and a return operation. In the test, one cycle carries both a status write that sets exception level and a return code, while error level is clear. The check then confirms three results: `eret_pc` shows the exception return address in that cycle, exception level reads back as zero afterwards because the return acted on the freshly written flag, and the link address reads 1 even though it held another value just before.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int unsigned XLEN = 32;

  localparam logic [4:0] NUM_INDEX  = 5'd0;
  localparam logic [4:0] NUM_HWEN   = 5'd7;
  localparam logic [4:0] NUM_ASID   = 5'd10;
  localparam logic [4:0] NUM_STATUS = 5'd12;
  localparam logic [4:0] NUM_CAUSE  = 5'd13;
  localparam logic [4:0] NUM_EPC    = 5'd14;
  localparam logic [4:0] NUM_VBASE  = 5'd15;
  localparam logic [4:0] NUM_LINK   = 5'd17;
  localparam logic [4:0] NUM_ERRPC  = 5'd30;

  localparam logic [XLEN-1:0] STATUS_WMASK = 32'hFA78_FF01;
  localparam logic [XLEN-1:0] CAUSE_WMASK  = 32'h00C0_0300;
  localparam logic [XLEN-1:0] ASID_WMASK   = 32'hFFFF_E0FF;
  localparam logic [XLEN-1:0] VBASE_KEEP   = 32'h3FFF_F000;
  localparam logic [XLEN-1:0] VBASE_FIXED  = 32'h8000_0000;

  localparam int unsigned BIT_IE  = 0;
  localparam int unsigned BIT_EXL = 1;
  localparam int unsigned BIT_ERL = 2;
  localparam int unsigned BIT_UM  = 4;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RET  = 2'd1,
    OP_EI   = 2'd2,
    OP_DI   = 2'd3
  } pcr_op_e;
endpackage

// File: rtl/pcr_status_unit.sv
module pcr_status_unit
  import pcr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [XLEN-1:0] wr_data,
  input  pcr_op_e         op,
  input  logic            dbg_mode,
  input  logic [7:0]      pend,
  output logic [XLEN-1:0] status_rd,
  output logic            exl,
  output logic            erl,
  output logic            um,
  output logic            irq_req
);
  logic [XLEN-1:0] st_q, st_b, st_n;
  logic exl_q, erl_q, um_q, irq_q;
  logic exl_b, erl_b, um_b, exl_n, erl_n;
  logic raise, drop;

  // write lands first, then the operation acts on the result
  always_comb begin
    st_b  = wr_hit ? (wr_data & STATUS_WMASK) : st_q;
    exl_b = wr_hit ? wr_data[BIT_EXL] : exl_q;
    erl_b = wr_hit ? wr_data[BIT_ERL] : erl_q;
    um_b  = wr_hit ? wr_data[BIT_UM]  : um_q;
    st_n  = st_b;
    exl_n = exl_b;
    erl_n = erl_b;
    case (op)
      OP_EI:   st_n[BIT_IE] = 1'b1;
      OP_DI:   st_n[BIT_IE] = 1'b0;
      OP_RET:  if (erl_q) erl_n = 1'b0; else exl_n = 1'b0;
      default: ;
    endcase
  end

  assign raise = st_n[BIT_IE] & ~st_q[BIT_IE] & ~exl_n & ~erl_n & ~dbg_mode
               & (|(st_n[15:8] & pend));
  assign drop  = ~st_n[BIT_IE] & st_q[BIT_IE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      exl_q <= 1'b0;
      erl_q <= 1'b0;
      um_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      exl_q <= exl_n;
      erl_q <= erl_n;
      um_q  <= um_b;
      if (raise)     irq_q <= 1'b1;
      else if (drop) irq_q <= 1'b0;
    end
  end

  always_comb begin
    status_rd          = st_q;
    status_rd[BIT_EXL] = exl_q;
    status_rd[BIT_ERL] = erl_q;
    status_rd[BIT_UM]  = um_q;
  end

  assign exl     = exl_q;
  assign erl     = erl_q;
  assign um      = um_q;
  assign irq_req = irq_q;
endmodule

// File: rtl/pcr_reg_bank.sv
module pcr_reg_bank
  import pcr_pkg::*;
#(
  parameter int unsigned     IDX_W     = 4,
  parameter int unsigned     HWR_COUNT = 4,
  parameter logic [XLEN-1:0] PRID_VAL  = 32'h00A5_0001
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [4:0]           wr_num,
  input  logic [2:0]           wr_sel,
  input  logic [XLEN-1:0]      wr_data,
  input  logic [4:0]           rd_num,
  input  logic [2:0]           rd_sel,
  input  logic [XLEN-1:0]      status_rd,
  input  logic                 ret_op,
  input  logic                 erl_now,
  input  logic [5:0]           irq_lines,
  output logic [XLEN-1:0]      rd_data,
  output logic [XLEN-1:0]      eret_pc,
  output logic [7:0]           pend,
  output logic [HWR_COUNT-1:0] hwen,
  output logic [XLEN-1:0]      link_val,
  output logic                 tlb_flush
);
  logic [IDX_W-1:0]     idx_q;
  logic [HWR_COUNT-1:0] hwen_q;
  logic [XLEN-1:0]      asid_q, cause_q, epc_q, vbase_q, link_q, errpc_q, cause_rd;
  logic [5:0]           line_q;
  logic                 flush_q;

  function automatic logic hit(input logic [4:0] n, input logic [2:0] s);
    return wr_en && (wr_num == n) && (wr_sel == s);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      hwen_q  <= '0;
      asid_q  <= '0;
      cause_q <= '0;
      epc_q   <= '0;
      vbase_q <= VBASE_FIXED;
      link_q  <= '0;
      errpc_q <= '0;
      line_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      line_q  <= irq_lines;
      flush_q <= 1'b0;
      if (hit(NUM_INDEX, 3'd0)) idx_q  <= wr_data[IDX_W-1:0];
      if (hit(NUM_HWEN, 3'd0))  hwen_q <= wr_data[HWR_COUNT-1:0];
      if (hit(NUM_ASID, 3'd0)) begin
        asid_q  <= wr_data & ASID_WMASK;
        flush_q <= (wr_data[7:0] != asid_q[7:0]);
      end
      if (hit(NUM_CAUSE, 3'd0))
        cause_q <= (cause_q & ~CAUSE_WMASK) | (wr_data & CAUSE_WMASK);
      if (hit(NUM_EPC, 3'd0))   epc_q   <= wr_data;
      if (hit(NUM_VBASE, 3'd1)) vbase_q <= VBASE_FIXED | (wr_data & VBASE_KEEP);
      if (hit(NUM_ERRPC, 3'd0)) errpc_q <= wr_data;
      if (ret_op)                   link_q <= 32'd1;
      else if (hit(NUM_LINK, 3'd0)) link_q <= wr_data;
    end
  end

  assign cause_rd = (cause_q & CAUSE_WMASK) | {16'd0, line_q, 10'd0};
  assign pend     = cause_rd[15:8];

  always_comb begin
    rd_data = '0;
    case ({rd_num, rd_sel})
      {NUM_INDEX,  3'd0}: rd_data = {{(XLEN-IDX_W){1'b0}}, idx_q};
      {NUM_HWEN,   3'd0}: rd_data = {{(XLEN-HWR_COUNT){1'b0}}, hwen_q};
      {NUM_ASID,   3'd0}: rd_data = asid_q;
      {NUM_STATUS, 3'd0}: rd_data = status_rd;
      {NUM_CAUSE,  3'd0}: rd_data = cause_rd;
      {NUM_EPC,    3'd0}: rd_data = epc_q;
      {NUM_VBASE,  3'd0}: rd_data = PRID_VAL;
      {NUM_VBASE,  3'd1}: rd_data = vbase_q;
      {NUM_LINK,   3'd0}: rd_data = link_q;
      {NUM_ERRPC,  3'd0}: rd_data = errpc_q;
      default:            rd_data = '0;
    endcase
  end

  assign eret_pc   = erl_now ? errpc_q : epc_q;
  assign hwen      = hwen_q;
  assign link_val  = link_q;
  assign tlb_flush = flush_q;
endmodule

// File: rtl/pcr_hwr_gate.sv
module pcr_hwr_gate #(
  parameter int unsigned HWR_COUNT = 4
) (
  input  logic [HWR_COUNT-1:0] hwen,
  input  logic                 hwr_req,
  input  logic [4:0]           hwr_num,
  input  logic                 kernel,
  output logic                 hwr_fault
);
  logic [31:0] grant;

  for (genvar i = 0; i < 32; i++) begin : g_grant
    if (i < HWR_COUNT) begin : g_on
      assign grant[i] = hwen[i];
    end else begin : g_off
      assign grant[i] = 1'b0;
    end
  end

  assign hwr_fault = hwr_req & ~kernel & ~grant[hwr_num];
endmodule

// File: rtl/priv_ctrl_regs.sv
module priv_ctrl_regs
  import pcr_pkg::*;
#(
  parameter int unsigned     TLB_ENTRIES = 16,
  parameter int unsigned     HWR_COUNT   = 4,
  parameter logic [XLEN-1:0] PRID_VAL    = 32'h00A5_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_num,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_num,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic [1:0]  op_code,
  output logic [31:0] eret_pc,
  output logic [31:0] di_old,
  input  logic        dbg_mode,
  input  logic [5:0]  irq_lines,
  output logic        irq_req,
  input  logic        hwr_req,
  input  logic [4:0]  hwr_num,
  output logic        hwr_fault,
  output logic        tlb_flush
);
  localparam int unsigned IDX_W = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;

  pcr_op_e              op;
  logic                 status_hit, exl, erl, um, kernel;
  logic [XLEN-1:0]      status_rd, link_val;
  logic [7:0]           pend;
  logic [HWR_COUNT-1:0] hwen;

  assign op         = pcr_op_e'(op_code);
  assign status_hit = wr_en && (wr_num == NUM_STATUS) && (wr_sel == 3'd0);
  assign kernel     = ~um | exl | erl | dbg_mode;

  pcr_status_unit u_status (
    .clk, .rst_n, .wr_hit(status_hit), .wr_data, .op, .dbg_mode, .pend,
    .status_rd, .exl, .erl, .um, .irq_req
  );

  pcr_reg_bank #(.IDX_W(IDX_W), .HWR_COUNT(HWR_COUNT), .PRID_VAL(PRID_VAL)) u_bank (
    .clk, .rst_n, .wr_en, .wr_num, .wr_sel, .wr_data, .rd_num, .rd_sel,
    .status_rd, .ret_op(op == OP_RET), .erl_now(erl), .irq_lines,
    .rd_data, .eret_pc, .pend, .hwen, .link_val, .tlb_flush
  );

  pcr_hwr_gate #(.HWR_COUNT(HWR_COUNT)) u_hwr (
    .hwen, .hwr_req, .hwr_num, .kernel, .hwr_fault
  );

  assign di_old = status_rd;
endmodule

// File: rtl/pcr_checker.sv
module pcr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  op_code,
  input logic        wr_en,
  input logic [4:0]  wr_num,
  input logic [2:0]  wr_sel,
  input logic [4:0]  rd_num,
  input logic [2:0]  rd_sel,
  input logic [31:0] rd_data,
  input logic [31:0] status_rd,
  input logic [31:0] link_val,
  input logic        irq_req,
  input logic        tlb_flush
);
  AST_IRQ_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> status_rd[0] && !status_rd[1] && !status_rd[2]); // R4
  AST_DI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'd3) |=> !irq_req && !status_rd[0]); // R6
  AST_RET_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'd1) |=> (link_val == 32'd1)); // R8
  AST_RET_ERL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'd1 && status_rd[2]) |=> !status_rd[2]); // R8
  AST_FLUSH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> $past(wr_en && wr_num == 5'd10 && wr_sel == 3'd0)); // R12
  AST_VBASE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_num == 5'd15 && rd_sel == 3'd1) |-> rd_data[31:30] == 2'b10 && rd_data[11:0] == 12'd0); // R10
endmodule

bind priv_ctrl_regs pcr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .wr_en(wr_en), .wr_num(wr_num),
  .wr_sel(wr_sel), .rd_num(rd_num), .rd_sel(rd_sel), .rd_data(rd_data),
  .status_rd(status_rd), .link_val(link_val), .irq_req(irq_req), .tlb_flush(tlb_flush)
);

// File: tb/priv_ctrl_regs_bench.sv
`timescale 1ns/1ps
module priv_ctrl_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, dbg_mode = 1'b0, hwr_req = 1'b0;
  logic [4:0] wr_num = '0, rd_num = '0, hwr_num = '0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] op_code = '0;
  logic [5:0] irq_lines = '0;
  logic [31:0] rd_data, eret_pc, di_old;
  logic irq_req, hwr_fault, tlb_flush;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  priv_ctrl_regs u_priv_ctrl_regs (.*);

  typedef struct packed {
    logic [4:0]  num;
    logic [2:0]  sel;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // requirement numbers in the last field: R1 R2 R3 R10 R11 R12 R13
  localparam vec_t TBL [15] = '{
    '{5'd0,  3'd0, 32'hFFFF_FFFF, 32'h0000_000F, 8'd13},
    '{5'd7,  3'd0, 32'hFFFF_FFFF, 32'h0000_000F, 8'd11},
    '{5'd10, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_E0FF, 8'd12},
    '{5'd13, 3'd0, 32'hFFFF_FFFF, 32'h00C0_0300, 8'd3},
    '{5'd13, 3'd0, 32'h0000_0100, 32'h0000_0100, 8'd3},
    '{5'd13, 3'd0, 32'h0000_0300, 32'h0000_0300, 8'd3},
    '{5'd14, 3'd0, 32'h1234_5678, 32'h1234_5678, 8'd1},
    '{5'd30, 3'd0, 32'hA5A5_A5A4, 32'hA5A5_A5A4, 8'd1},
    '{5'd17, 3'd0, 32'h0000_1000, 32'h0000_1000, 8'd1},
    '{5'd15, 3'd1, 32'h0000_0000, 32'h8000_0000, 8'd10},
    '{5'd15, 3'd1, 32'hFFFF_FFFF, 32'hBFFF_F000, 8'd10},
    '{5'd12, 3'd0, 32'hFFFF_FFFF, 32'hFA78_FF17, 8'd2},
    '{5'd12, 3'd0, 32'h0000_0000, 32'h0000_0000, 8'd2},
    '{5'd15, 3'd0, 32'h0000_0000, 32'h00A5_0001, 8'd1},
    '{5'd3,  3'd0, 32'hFFFF_FFFF, 32'h0000_0000, 8'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_num = n; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] n, input logic [2:0] s, output logic [31:0] v);
    rd_num = n; rd_sel = s;
    #1 v = rd_data;
  endtask

  task automatic op_cycle(input logic [1:0] c, output logic [31:0] pc, output logic [31:0] old);
    @(negedge clk);
    op_code = c;
    #1 pc = eret_pc; old = di_old;
    @(negedge clk);
    op_code = 2'd0;
  endtask

  task automatic fault_at(input logic [4:0] n, output logic f);
    hwr_req = 1'b1; hwr_num = n;
    #1 f = hwr_fault;
    hwr_req = 1'b0;
  endtask

  initial begin
    logic [31:0] v, pc, old;
    logic f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    rd(5'd12, 3'd0, v); check("R1 status reset", v, 32'h0);
    rd(5'd15, 3'd1, v); check("R1 vbase reset", v, 32'h8000_0000);
    rd(5'd17, 3'd0, v); check("R1 link reset", v, 32'h0);
    check("R1 irq reset", {31'd0, irq_req}, 32'd0);
    check("R1 flush reset", {31'd0, tlb_flush}, 32'd0);

    for (int i = 0; i < 15; i++) begin
      wr(TBL[i].num, TBL[i].sel, TBL[i].wd);
      rd(TBL[i].num, TBL[i].sel, v);
      check($sformatf("R%0d table row %0d", TBL[i].req, i), v, TBL[i].exp);
    end
    check("R4 no raise with exception level", {31'd0, irq_req}, 32'd0);

    // R4: raise with soft pending bit 8 unmasked
    wr(5'd12, 3'd0, 32'h0000_0101);
    check("R4 raise", {31'd0, irq_req}, 32'd1);
    // R5: hold on repeated IE and on cause write
    wr(5'd12, 3'd0, 32'h0000_0101);
    check("R5 hold on IE 1->1", {31'd0, irq_req}, 32'd1);
    wr(5'd13, 3'd0, 32'h0);
    check("R5 hold on cause write", {31'd0, irq_req}, 32'd1);
    wr(5'd13, 3'd0, 32'h0000_0300);
    wr(5'd12, 3'd0, 32'h0000_0100);
    check("R5 drop", {31'd0, irq_req}, 32'd0);
    // R4: no raise when mask misses pending
    wr(5'd12, 3'd0, 32'h0000_0401);
    check("R4 masked miss", {31'd0, irq_req}, 32'd0);
    wr(5'd12, 3'd0, 32'h0);
    dbg_mode = 1'b1;
    wr(5'd12, 3'd0, 32'h0000_0101);
    check("R4 debug blocks", {31'd0, irq_req}, 32'd0);
    wr(5'd12, 3'd0, 32'h0000_0100);
    dbg_mode = 1'b0;

    // R3: hardware line into cause bit 10
    irq_lines = 6'd1;
    @(negedge clk);
    rd(5'd13, 3'd0, v); check("R3 line registered", v, 32'h0000_0700);
    wr(5'd12, 3'd0, 32'h0000_0401);
    check("R4 raise by line", {31'd0, irq_req}, 32'd1);

    // R6: disable
    op_cycle(2'd3, pc, old);
    check("R6 old status", old, 32'h0000_0401);
    check("R6 irq dropped", {31'd0, irq_req}, 32'd0);
    rd(5'd12, 3'd0, v); check("R6 IE cleared", v, 32'h0000_0400);
    // R7: enable
    op_cycle(2'd2, pc, old);
    check("R7 irq raised", {31'd0, irq_req}, 32'd1);
    rd(5'd12, 3'd0, v); check("R7 IE set", v, 32'h0000_0401);
    op_cycle(2'd3, pc, old);
    irq_lines = 6'd0;

    // R8: return
    wr(5'd14, 3'd0, 32'h0000_1000);
    wr(5'd30, 3'd0, 32'h0000_2000);
    wr(5'd17, 3'd0, 32'h0000_0055);
    wr(5'd12, 3'd0, 32'h0000_0006);
    rd(5'd12, 3'd0, v); check("R2 flags read", v, 32'h0000_0006);
    op_cycle(2'd1, pc, old);
    check("R8 pc error level", pc, 32'h0000_2000);
    rd(5'd12, 3'd0, v); check("R8 error level cleared", v, 32'h0000_0002);
    rd(5'd17, 3'd0, v); check("R8 link set", v, 32'h1);
    op_cycle(2'd1, pc, old);
    check("R8 pc exception level", pc, 32'h0000_1000);
    rd(5'd12, 3'd0, v); check("R8 exception level cleared", v, 32'h0);

    // R9: status write and return in the same cycle
    wr(5'd17, 3'd0, 32'h0000_0077);
    @(negedge clk);
    wr_en = 1'b1; wr_num = 5'd12; wr_sel = 3'd0; wr_data = 32'h0000_0002; op_code = 2'd1;
    #1 pc = eret_pc;
    @(negedge clk);
    wr_en = 1'b0; op_code = 2'd0;
    check("R9 pc from old flag", pc, 32'h0000_1000);
    rd(5'd12, 3'd0, v); check("R9 written flag cleared", v, 32'h0);
    rd(5'd17, 3'd0, v); check("R9 link wins", v, 32'h1);

    // R11: user hardware reads
    wr(5'd12, 3'd0, 32'h0000_0010);
    fault_at(5'd2, f); check("R11 enabled ok", {31'd0, f}, 32'd0);
    wr(5'd7, 3'd0, 32'h0000_0005);
    fault_at(5'd1, f); check("R11 disabled faults", {31'd0, f}, 32'd1);
    fault_at(5'd2, f); check("R11 bit2 ok", {31'd0, f}, 32'd0);
    fault_at(5'd5, f); check("R11 out of range", {31'd0, f}, 32'd1);
    wr(5'd12, 3'd0, 32'h0);
    fault_at(5'd1, f); check("R11 kernel ok", {31'd0, f}, 32'd0);

    // R12: flush pulse
    wr(5'd10, 3'd0, 32'h0000_0012);
    check("R12 flush on change", {31'd0, tlb_flush}, 32'd1);
    @(negedge clk);
    check("R12 one cycle", {31'd0, tlb_flush}, 32'd0);
    wr(5'd10, 3'd0, 32'h0000_2012);
    check("R12 no flush same id", {31'd0, tlb_flush}, 32'd0);
    rd(5'd10, 3'd0, v); check("R12 masked value", v, 32'h0000_2012);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule